// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an 8-line general-purpose I/O port that sits behind a plain register-style bus. The bus has an address, a write strobe, a read strobe, write data and registered read data. Each pin has a direction bit and an output data bit. Each pin input passes through a two-flop synchronizer. The direction bit drives the pad output enable directly.

Data accesses are masked by the address. Address bits [9:2] act as an 8-bit pin mask, and a set bit (n+2) selects pin n. A write changes only the selected pins, so software can flip one line without first reading the register. A read returns the current pin levels for the selected pins and zero for all other pins. The pin level is the driven value on an output pin and the synchronized pad value on an input pin.

The direction register is a separate byte-wide word at byte offset 0x400. Every offset outside the data window and the direction word reads as zero and ignores writes. The external reset is asynchronous and active-low, and its release is synchronized to the clock.

Top module: `gpio_mask_port`

## Requirements
- R1: Once reset has been applied, the direction register, the output data register, `pad_oe` and `pad_out` are all zero, so every pin is an input.
- R2: A write where address bits [11:10] are 0 is a data write. Pin n takes write-data bit n only if address bit (n+2) is set. Every other pin keeps its output value. The result shows on `pad_out` after the write's clock edge.
- R3: A read where address bits [11:10] are 0 returns, one clock after the read strobe, the pin level for each pin whose address bit (n+2) is set. It returns 0 for every other pin.
- R4: A write to byte offset 0x400 loads the direction register. Bit n = 1 makes pin n an output and bit n = 0 makes it an input. `pad_oe[n]` equals direction bit n. A read of offset 0x400 returns the direction register.
- R5: A data write lands in the output register whatever the pin's direction. A value written again after the pin is switched to output is the value that drives `pad_out`.
- R6: An input pin is read through two synchronizer flops. A change on `pad_in` is not seen by a read strobe at the first clock edge after the change. It is seen by a read at the third edge after the change.
- R7: A read of an output pin returns the driven output value, not `pad_in`.
- R8: A read from any other offset (for example 0x404 or 0x800) returns 0. A write to such an offset changes neither `pad_out` nor `pad_oe`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, release synchronized inside |
| bus_addr | input | 12 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after the read strobe and held until the next read |
| pad_in | input | 8 | Pad input levels, asynchronous |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables, 1 = drive |

## Verification
A wrong mask decode shows on `pad_out` one clock after a data write, as pins outside the mask that change or pins inside it that do not. A bad direction register shows on `pad_oe` at the same clock, and also in which pins a read reports from `pad_in` and which from the driven value. A synchronizer that has too few or too many stages shows as a read one cycle early or one cycle late after a pad change. Random input patterns, masks and directions are compared against a bench model one read at a time, so a single misrouted bit shows up within the read that follows it.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
  // First address bit used as a pin mask; the word offset is the low two bits.
  localparam int unsigned MASK_LSB = 2;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_NONE = 2'd2
  } port_sel_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_mask_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned PINS   = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output port_sel_e         sel,
  output logic [PINS-1:0]   mask
);
  localparam int unsigned REGION_LSB = MASK_LSB + PINS;
  localparam int unsigned REGION_W   = ADDR_W - REGION_LSB;

  logic [REGION_W-1:0] region;
  logic [PINS-1:0]     mid;

  assign region = addr[ADDR_W-1:REGION_LSB];
  assign mid    = addr[REGION_LSB-1:MASK_LSB];
  assign mask   = mid;

  always_comb begin
    if (region == '0) begin
      sel = SEL_DATA;
    end else if (region == REGION_W'(1) && mid == '0) begin
      sel = SEL_DIR;
    end else begin
      sel = SEL_NONE;
    end
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_mask_pkg::*;
#(
  parameter int unsigned PINS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  port_sel_e       sel,
  input  logic [PINS-1:0] mask,
  input  logic [PINS-1:0] wdata,
  output logic [PINS-1:0] dir_q,
  output logic [PINS-1:0] out_q
);
  logic            dir_en;
  logic            out_en;
  logic [PINS-1:0] dir_d;
  logic [PINS-1:0] out_d;

  // Next-state: masked merge for data, plain load for direction.
  always_comb begin
    dir_en = wr && (sel == SEL_DIR);
    out_en = wr && (sel == SEL_DATA);
    dir_d  = wdata;
    out_d  = (out_q & ~mask) | (wdata & mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
    end else begin
      if (dir_en) dir_q <= dir_d;
      if (out_en) out_q <= out_d;
    end
  end
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_mask_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned PINS   = 8
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe
);
  logic            rst_n;
  port_sel_e       sel;
  logic [PINS-1:0] mask;
  logic [PINS-1:0] dir_q;
  logic [PINS-1:0] out_q;
  logic [PINS-1:0] in_sync;
  logic [PINS-1:0] level;
  logic [PINS-1:0] rdata_d;
  logic [PINS-1:0] rdata_q;

  // Reset release synchronizer: asserts at once, lets go on a clock edge.
  gpio_in_sync #(.W(1)) u_rst_sync (
    .clk   (clk),
    .rst_n (arst_n),
    .d     (1'b1),
    .q     (rst_n)
  );

  gpio_in_sync #(.W(PINS)) u_in_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (in_sync)
  );

  gpio_addr_decode #(.ADDR_W(ADDR_W), .PINS(PINS)) u_dec (
    .addr (bus_addr),
    .sel  (sel),
    .mask (mask)
  );

  gpio_port_regs #(.PINS(PINS)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (bus_wr),
    .sel   (sel),
    .mask  (mask),
    .wdata (bus_wdata),
    .dir_q (dir_q),
    .out_q (out_q)
  );

  assign level = (dir_q & out_q) | (~dir_q & in_sync);

  always_comb begin
    case (sel)
      SEL_DATA: rdata_d = level & mask;
      SEL_DIR:  rdata_d = dir_q;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign pad_out   = out_q;
  assign pad_oe    = dir_q;
endmodule

// File: rtl/gpio_mask_chk.sv
module gpio_mask_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned PINS   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [PINS-1:0]   bus_wdata,
  input logic [PINS-1:0]   bus_rdata,
  input logic [PINS-1:0]   pad_out,
  input logic [PINS-1:0]   pad_oe
);
  localparam int unsigned TOP_LSB = PINS + 2;

  logic            in_data;
  logic            in_dir;
  logic [PINS-1:0] amask;

  assign amask   = bus_addr[TOP_LSB-1:2];
  assign in_data = (bus_addr >> TOP_LSB) == '0;
  assign in_dir  = bus_addr == (ADDR_W'(1) << TOP_LSB);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (pad_oe == '0 && pad_out == '0));

  // R2
  masked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && in_data) |=>
      ((pad_out & $past(amask)) == ($past(bus_wdata) & $past(amask))) &&
      ((pad_out & ~$past(amask)) == ($past(pad_out) & ~$past(amask))));

  // R3
  read_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && in_data) |=> ((bus_rdata & ~$past(amask)) == '0));

  // R4
  dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && in_dir) |=> (pad_oe == $past(bus_wdata)));

  // R8
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !in_data && !in_dir) |=> ($stable(pad_out) && $stable(pad_oe)));

  // R8
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !in_data && !in_dir) |=> (bus_rdata == '0));
endmodule

bind gpio_mask_port gpio_mask_chk #(.ADDR_W(ADDR_W), .PINS(PINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe)
);

// File: tb/test_gpio_mask_port.sv
module test_gpio_mask_port;
  logic        clk;
  logic        arst_n;
  logic [11:0] bus_addr;
  logic        bus_wr;
  logic        bus_rd;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [7:0]  pad_in;
  logic [7:0]  pad_out;
  logic [7:0]  pad_oe;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [7:0] m_dir;
  logic [7:0] m_out;
  logic [7:0] got;

  gpio_mask_port i_gpio_mask_port (
    .clk       (clk),
    .arst_n    (arst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [11:0] data_addr(input logic [7:0] m);
    return {2'b00, m, 2'b00};
  endfunction

  function automatic logic [7:0] exp_level(input logic [7:0] d, input logic [7:0] o,
                                           input logic [7:0] pin);
    return (d & o) | (~d & pin);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
    if (a[11:10] == 2'b00) m_out = (m_out & ~a[9:2]) | (d & a[9:2]);
    else if (a == 12'h400) m_dir = d;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    bus_addr = a;
    bus_rd   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    arst_n    = 1'b1;
    bus_addr  = '0;
    bus_wr    = 1'b0;
    bus_rd    = 1'b0;
    bus_wdata = '0;
    pad_in    = 8'h00;
    m_dir     = '0;
    m_out     = '0;
    #1 arst_n = 1'b0;
    idle(3);
    arst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk("R1 oe", pad_oe, 8'h00);
    chk("R1 out", pad_out, 8'h00);
    rd(12'h400, got);
    chk("R1 dir read", got, 8'h00);

    // R4 direction register
    wr(12'h400, 8'hF0);
    chk("R4 oe", pad_oe, 8'hF0);
    rd(12'h400, got);
    chk("R4 dir read", got, 8'hF0);

    // R2 masked writes
    wr(data_addr(8'h04), 8'hFF);
    chk("R2 single pin", pad_out, 8'h04);
    wr(data_addr(8'h81), 8'h01);
    chk("R2 two pins", pad_out, 8'h05);
    wr(data_addr(8'h00), 8'hFF);
    chk("R2 empty mask", pad_out, 8'h05);

    // R5 write while input, rewrite after switching to output
    wr(12'h400, 8'h00);
    wr(data_addr(8'h02), 8'h02);
    wr(12'h400, 8'h02);
    wr(data_addr(8'h02), 8'h00);
    chk("R5 rewrite wins", pad_out & 8'h02, 8'h00);
    wr(data_addr(8'h02), 8'h02);
    chk("R5 second rewrite", pad_out & 8'h02, 8'h02);

    // R6 synchronizer latency
    wr(12'h400, 8'h00);
    pad_in = 8'h00;
    idle(3);
    pad_in = 8'h3C;
    rd(data_addr(8'hFF), got);
    chk("R6 too early", got, 8'h00);
    idle(2);
    rd(data_addr(8'hFF), got);
    chk("R6 after sync", got, 8'h3C);

    // R3 masked read of inputs
    rd(data_addr(8'h0F), got);
    chk("R3 masked read", got, 8'h0C);

    // R7 outputs read driven value
    wr(12'h400, 8'hFF);
    wr(data_addr(8'hFF), 8'h5A);
    pad_in = 8'hA5;
    idle(3);
    rd(data_addr(8'hFF), got);
    chk("R7 driven value", got, 8'h5A);

    // R8 unmapped offsets
    wr(12'h800, 8'h00);
    chk("R8 write out", pad_out, 8'h5A);
    chk("R8 write oe", pad_oe, 8'hFF);
    wr(12'h404, 8'h00);
    chk("R8 near dir oe", pad_oe, 8'hFF);
    rd(12'h800, got);
    chk("R8 read far", got, 8'h00);
    rd(12'h404, got);
    chk("R8 read near", got, 8'h00);

    // Random mix: R2 R3 R4 R7
    for (int it = 0; it < 300; it++) begin
      logic [7:0] m;
      logic [7:0] v;
      v = 8'($urandom);
      m = 8'($urandom);
      case ($urandom % 3)
        0: begin
          wr(12'h400, v);
          chk("R4 random oe", pad_oe, m_dir);
        end
        1: begin
          wr(data_addr(m), v);
          chk("R2 random out", pad_out, m_out);
        end
        default: begin
          pad_in = v;
          idle(2);
          rd(data_addr(m), got);
          chk("R3 random read", got, exp_level(m_dir, m_out, v) & m);
        end
      endcase
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule